// File: doc/BRIEF.md
# Double-Buffered Clock Register File

This block holds the eight clock registers that occupy the top eight byte addresses of an 8K byte space. It sits between a simple byte bus and a separate time-counter block. Software sees a visible copy of the time. The counters keep their own live values. When the clock is not halted, the block refreshes the visible copy from the live counters one cycle after each one-second strobe. Two control bits halt that refresh. The read bit freezes the copy so software can read a consistent snapshot. The write bit freezes it so software can write a new time. When software clears the write bit, the block pulses a load strobe that carries the written time into the counters.

A reference enable at 32.768 kHz drives a prescaler. The prescaler makes the one-second strobe and a 512 Hz toggle. The oscillator-stop bit holds both of them. The frequency-test bit puts the 512 Hz toggle on the least significant bit of the seconds register whenever that register is read. Every bit that carries neither time nor control stores and returns data like plain RAM, and a refresh never touches it.

Top module: `rtc_shadow_regs`

## Requirements
- R1: `reg_hit` is high exactly when address bits 12:3 are all ones. Offsets 0 to 7 select control, seconds, minutes, hour, day, date, month and year, in that order.
- R2: A selected write stores the full byte at its offset, and a read returns it. Bits outside the time fields survive every refresh. The time fields are: seconds 0x7F, minutes 0x7F, hour 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF, control none.
- R3: Outside halt, the cycle after `sec_tick` replaces the time field of register k (k = 1..7) with byte k-1 of `cnt_now` (`cnt_now[7:0]` = seconds).
- R4: While control bit 6 (read bit) is 1, the visible registers do not change without a bus write, while the live counters keep advancing. After the bit is cleared, the next strobe refreshes all registers together.
- R5: Control bit 7 (write bit) also halts the refresh. A bus write that changes it from 1 to 0 raises `cnt_load` for exactly one cycle, starting on the following cycle. `cnt_load_data` byte k-1 carries the time field of register k.
- R6: Seconds bit 7 stops the oscillator: while it is 1, `sec_tick` stays low and the 512 Hz toggle holds. After reset it is 1, seconds reads 0x80 and every other register reads 0x00.
- R7: With day bit 6 set and the oscillator running, a seconds read returns bit 0 from a toggle that flips every TOGGLE_DIV reference ticks. In every other case bit 0 is the stored bit.
- R8: When a bus write and a refresh land on the same register in the same cycle, the written byte wins.
- R9: `bus_rdata` is 0x00 unless a read is selected with `reg_hit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | 32.768 kHz reference enable |
| bus_sel | input | 1 | Bus select |
| bus_we | input | 1 | Write strobe, read when low |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| reg_hit | output | 1 | Address falls in the clock registers |
| sec_tick | output | 1 | One-second strobe to the counters |
| cnt_now | input | 56 | Live counter values, seconds in the low byte |
| cnt_load | output | 1 | Load strobe to the counters |
| cnt_load_data | output | 56 | Time values to load, seconds in the low byte |

## Verification
A refresh and a bus write can fall in the same cycle. The bench provokes this by finding a cycle in which `sec_tick` is high and placing a write to the seconds register on the next edge, which is the refresh edge. The written seconds value must read back unchanged. In the same check, the minutes register must show the live counter value, which shows that the refresh did take place on the other registers. A second overlap is a load strobe that lands on a refresh edge. The bench judges this through the seconds value seen after the next strobe.

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs #(
  parameter int ADDR_W      = 13,
  parameter int REF_PER_SEC = 32768,
  parameter int TOGGLE_DIV  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reg_hit,
  output logic              sec_tick,
  input  logic [55:0]       cnt_now,
  output logic              cnt_load,
  output logic [55:0]       cnt_load_data
);

  localparam int RW = (REF_PER_SEC > 2) ? $clog2(REF_PER_SEC) : 1;
  localparam int TW = (TOGGLE_DIV > 2) ? $clog2(TOGGLE_DIV) : 1;
  localparam logic [RW-1:0] REF_LAST = RW'(REF_PER_SEC - 1);
  localparam logic [TW-1:0] TGL_LAST = TW'(TOGGLE_DIV - 1);
  localparam logic [63:0] TIME_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h07,
                                       8'h3F, 8'h7F, 8'h7F, 8'h00};

  logic [7:0]    regs [8];
  logic [63:0]   regs_flat;
  logic [2:0]    idx;
  logic          wr_hit, rd_hit, halt, osc_run, ft_en;
  logic          tick_d, refresh, ft_q;
  logic [RW-1:0] ref_cnt;
  logic [TW-1:0] tgl_cnt;
  logic [7:0]    rd_word;

  assign idx     = bus_addr[2:0];
  assign reg_hit = &bus_addr[ADDR_W-1:3];
  assign wr_hit  = bus_sel & bus_we & reg_hit;
  assign rd_hit  = bus_sel & ~bus_we & reg_hit;
  assign halt    = regs[0][7] | regs[0][6];
  assign osc_run = ~regs[1][7];
  assign ft_en   = regs[4][6];
  assign sec_tick = ref_tick & osc_run & (ref_cnt == REF_LAST);
  assign refresh  = tick_d & ~halt & ~cnt_load;

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = regs[g];
    end
    for (g = 1; g < 8; g++) begin : g_load
      assign cnt_load_data[(g-1)*8 +: 8] = regs[g] & TIME_MASK[g*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      tgl_cnt <= '0;
      ft_q    <= 1'b0;
      tick_d  <= 1'b0;
    end else begin
      tick_d <= sec_tick;
      if (ref_tick && osc_run) begin
        ref_cnt <= (ref_cnt == REF_LAST) ? '0 : ref_cnt + 1'b1;
        if (tgl_cnt == TGL_LAST) begin
          tgl_cnt <= '0;
          ft_q    <= ~ft_q;
        end else begin
          tgl_cnt <= tgl_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= (i == 1) ? 8'h80 : 8'h00;
      cnt_load <= 1'b0;
    end else begin
      cnt_load <= wr_hit && (idx == 3'd0) && regs[0][7] && !bus_wdata[7];
      if (wr_hit && idx == 3'd0) regs[0] <= bus_wdata;
      for (int i = 1; i < 8; i++) begin
        if (wr_hit && idx == 3'(i))
          regs[i] <= bus_wdata;
        else if (refresh)
          regs[i] <= (regs[i] & ~TIME_MASK[i*8 +: 8]) |
                     (cnt_now[(i-1)*8 +: 8] & TIME_MASK[i*8 +: 8]);
      end
    end
  end

  always_comb begin
    rd_word = regs[idx];
    if (idx == 3'd1 && ft_en && osc_run) rd_word[0] = ft_q;
  end
  assign bus_rdata = rd_hit ? rd_word : 8'h00;

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_hit) |=> $stable(regs_flat));

  // R5
  load_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == 3'd0 && regs[0][7] && !bus_wdata[7]) |=> cnt_load);

  // R5
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);

  // R6
  osc_stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> !sec_tick);

  // R6
  osc_stop_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !(wr_hit && idx == 3'd1)) |=> $stable(ft_q));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_rtc_shadow_regs.sv
`timescale 1ns/1ps
module tb_rtc_shadow_regs;
  logic        clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        reg_hit, sec_tick, cnt_load;
  logic [55:0] cnt_now, cnt_load_data;
  int checks = 0, fails = 0;

  localparam logic [55:0] MDL_INIT = 56'h24_06_15_03_12_30_10;
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'h55, 8'h55}, {3'd1, 8'h25, 8'h25}, {3'd2, 8'h59, 8'h59},
    {3'd3, 8'h23, 8'h23}, {3'd4, 8'hA5, 8'hA5}, {3'd5, 8'hF1, 8'hF1},
    {3'd6, 8'hE9, 8'hE9}, {3'd7, 8'h99, 8'h99}};

  always #2.5 clk = ~clk;

  rtc_shadow_regs #(.ADDR_W(13), .REF_PER_SEC(16), .TOGGLE_DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reg_hit(reg_hit), .sec_tick(sec_tick),
    .cnt_now(cnt_now), .cnt_load(cnt_load), .cnt_load_data(cnt_load_data));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_now <= MDL_INIT;
    else if (cnt_load) cnt_now <= cnt_load_data;
    else if (sec_tick) cnt_now[6:0] <= cnt_now[6:0] + 7'd1;
  end

  function automatic logic [7:0] tmask(int k);
    case (k)
      1, 2: return 8'h7F;
      3, 5: return 8'h3F;
      4: return 8'h07;
      6: return 8'h1F;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {10'h3FF, off}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {10'h3FF, off};
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_sec();
    int n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick && n < 100);
    if (n >= 100) chk("R6 strobe missing", 0, 1);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_lsb(input int cycles, output int flips);
    logic last, cur;
    flips = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 13'h1FF9;
    #1 last = bus_rdata[0];
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #1 cur = bus_rdata[0];
      if (cur != last) flips++;
      last = cur;
    end
    bus_sel = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] vis [8];
    logic [55:0] expl;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset contents
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), v);
      chk("R6 reset value", v, (k == 1) ? 8'h80 : 8'h00);
    end
    n = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (sec_tick) n++; end
    chk("R6 stopped no strobe", n, 0);
    chk("R5 no load at reset", cnt_load, 0);

    // R1 decode
    @(negedge clk); bus_addr = 13'h1FF8; #1 chk("R1 hit low edge", reg_hit, 1);
    bus_addr = 13'h1FF7; #1 chk("R1 miss below", reg_hit, 0);
    bus_addr = 13'h0FFF; #1 chk("R1 miss top bit", reg_hit, 0);

    // R2 vector table under read halt
    wr(3'd0, 8'h40);
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk("R2 store readback", v, VEC[i][7:0]);
    end
    // R4 frozen over two strobes
    wait_sec();
    wait_sec();
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][18:16], v);
      chk("R4 frozen under read bit", v, VEC[i][7:0]);
    end

    // R3 / R4 release and refresh, RAM bits kept
    wr(3'd0, 8'h15);
    wait_sec();
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), v);
      vis[k] = v;
      if (k == 0) chk("R2 control RAM bits", v, 8'h15);
      else chk("R3 refresh merge", v,
               (VEC[k][7:0] & ~tmask(k)) | (cnt_now[(k-1)*8 +: 8] & tmask(k)));
    end
    chk("R4 counters advanced", cnt_now[6:0] > 7'h10, 1);

    // R5 write bit
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h05);
    wr(3'd2, 8'h11);
    wait_sec();
    rd(3'd1, v); chk("R5 write halt seconds", v, 8'h05);
    rd(3'd2, v); chk("R5 write halt minutes", v, 8'h11);
    vis[1] = 8'h05; vis[2] = 8'h11;
    for (int k = 1; k < 8; k++) expl[(k-1)*8 +: 8] = vis[k] & tmask(k);
    wr(3'd0, 8'h00);
    chk("R5 load pulse", cnt_load, 1);
    chk("R5 load data", cnt_load_data, expl);
    @(negedge clk);
    chk("R5 load single cycle", cnt_load, 0);
    wait_sec();
    rd(3'd1, v); chk("R5 loaded counters", v, 8'h06);
    rd(3'd2, v); chk("R5 loaded minutes", v, 8'h11);

    // R8 write on the refresh edge
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick && n < 100);
    wr(3'd1, 8'h33);
    rd(3'd1, v); chk("R8 write wins", v, 8'h33);
    rd(3'd2, v); chk("R8 other refreshed", v, cnt_now[15:8] & 8'h7F);

    // R7 frequency test
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h40);
    count_lsb(32, n);
    chk("R7 toggle running", (n >= 6 && n <= 9), 1);
    wr(3'd4, 8'h00);
    count_lsb(32, n);
    chk("R7 no toggle test off", n, 0);
    rd(3'd1, v); chk("R7 stored lsb", v, 8'h00);
    wr(3'd4, 8'h40);
    wr(3'd1, 8'h80);
    count_lsb(32, n);
    chk("R7 no toggle osc stopped", n, 0);
    n = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (sec_tick) n++; end
    chk("R6 stop bit holds strobe", n, 0);

    // R9 idle bus
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 13'h1FFC;
    #1 chk("R9 unselected read", bus_rdata, 8'h00);
    bus_sel = 1'b1; bus_addr = 13'h1FF0;
    #1 chk("R9 miss read", bus_rdata, 8'h00);
    bus_sel = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule